// File: doc/BRIEF.md
# Pipelined Block-Table CRC-32 Engine

This block computes a CRC-32 remainder over a message that arrives as a stream of 128-bit beats, one beat per clock. Each beat is split into four 32-bit blocks. Every block except the rightmost is advanced to its place in the message by a fixed "append N zero bytes" transform. The running remainder from earlier beats is advanced by sixteen zero bytes. All of these terms are XOR-combined. Each transform is GF(2)-linear, so it is built at elaboration as a 32x32 XOR matrix derived from the generator polynomial. No stored table content is used.

A registered pre-XOR stage folds the block terms into two partial sums. This keeps the feedback loop through the remainder register short. The result appears on a dedicated output two cycles after the beat that closes the message, and it is qualified by a one-cycle valid pulse. Messages may follow each other with no idle cycle between them. A start input discards whatever has been accumulated.

Top module: `crc32_blockpipe`

## Requirements
- R1: The result is the remainder of the message polynomial divided by G(x) = x^32 + 0x04C11DB7 (low 32 coefficient bits). The initial remainder is zero, and there is no bit reflection and no final inversion. Within a beat, bit 127 is the earliest message bit and bit 0 is the latest. Beats enter in arrival order.
- R2: One beat is accepted on every clock in which `beat_valid_i` is high. A message may span any number of beats.
- R3: `crc_valid_o` is high for exactly one cycle, two cycles after the cycle in which an accepted beat had `beat_last_i` high. It is never high at any other time.
- R4: A cycle with `beat_valid_i` low is a bubble. The data and last inputs in that cycle are ignored, and the accumulated remainder is unchanged.
- R5: The first accepted beat after a beat with last set starts a new message from a zero remainder. This holds even when it arrives in the very next cycle.
- R6: `start_i` discards the accumulated remainder. If it comes together with a valid beat, that beat is the first beat of the new message. If it comes alone, the next valid beat is the first beat.
- R7: A `start_i` in the cycle right after a last beat does not alter the result of the message that just ended.
- R8: After reset, `crc_o` is zero and `crc_valid_o` is low. `crc_o` holds the most recent result for as long as `crc_valid_o` stays low.
- R9: A single-beat message whose only nonzero bits lie in bits 31:0 yields those 32 bits unchanged. An all-zero message yields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Discard accumulated remainder; next (or same-cycle) beat begins a message |
| beat_valid_i | input | 1 | Beat on `beat_data_i` is accepted this cycle |
| beat_last_i | input | 1 | Accepted beat closes the message |
| beat_data_i | input | 128 | Four 32-bit blocks, bit 127 first in message order |
| crc_o | output | 32 | Most recent message remainder |
| crc_valid_o | output | 1 | One-cycle pulse marking a new `crc_o` |

## Verification
Two things can land in the same cycle. One is the final accumulate of a finished message, whose last beat is still sitting in the pre-XOR register. The other is the arrival of the next message's first beat, or of a start request. The bench provokes this with back-to-back random messages that have no idle cycles between them, with a start bubble placed right after a last beat, and with start coinciding with a valid beat. Each result is judged against a bit-serial division model in the bench, both for its value and for the exact cycle its valid pulse appears.

// File: rtl/crc_blockpipe_pkg.sv
package crc_blockpipe_pkg;

   localparam int MAX_W = 64;

   typedef struct packed {
      logic valid;
      logic first;
      logic last;
   } beat_ctl_t;

   // Column 'col' of the matrix that multiplies a remainder by x^shift mod G.
   function automatic logic [MAX_W-1:0] xpow_col(input int width,
                                                  input logic [MAX_W-1:0] poly,
                                                  input int col,
                                                  input int shift);
      logic [MAX_W-1:0] v;
      logic [MAX_W-1:0] mask;
      logic             top;
      mask = (width >= MAX_W) ? '1 : ((MAX_W'(1) << width) - MAX_W'(1));
      v    = MAX_W'(1) << col;
      for (int i = 0; i < shift; i++) begin
         top = v[width-1];
         v   = (v << 1) & mask;
         if (top) v = v ^ (poly & mask);
      end
      return v;
   endfunction

endpackage

// File: rtl/crc_zext_xform.sv
module crc_zext_xform #(
   parameter int                CRC_W = 32,
   parameter logic [CRC_W-1:0]  POLY  = 32'h04C1_1DB7,
   parameter int                SHIFT = 0
) (
   input  logic [CRC_W-1:0] vec_i,
   output logic [CRC_W-1:0] vec_o
);
   import crc_blockpipe_pkg::*;

   if (CRC_W > MAX_W || CRC_W < 2) begin : g_bad_width
      $error("crc_zext_xform: CRC_W out of range");
   end
   if (SHIFT < 0) begin : g_bad_shift
      $error("crc_zext_xform: SHIFT must not be negative");
   end

   if (SHIFT == 0) begin : g_pass
      // A value shorter than the generator degree is its own remainder.
      assign vec_o = vec_i;
   end else begin : g_matrix
      logic [CRC_W-1:0] cols [CRC_W];
      for (genvar j = 0; j < CRC_W; j++) begin : g_col
         localparam logic [MAX_W-1:0] COL_FULL = xpow_col(CRC_W, MAX_W'(POLY), j, SHIFT);
         assign cols[j] = vec_i[j] ? COL_FULL[CRC_W-1:0] : '0;
      end
      always_comb begin
         vec_o = '0;
         for (int j = 0; j < CRC_W; j++) vec_o = vec_o ^ cols[j];
      end
   end

endmodule

// File: rtl/crc_prexor_stage.sv
module crc_prexor_stage #(
   parameter int                CRC_W  = 32,
   parameter logic [CRC_W-1:0]  POLY   = 32'h04C1_1DB7,
   parameter int                BLOCKS = 4,
   parameter int                GROUPS = 2
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic [BLOCKS*CRC_W-1:0]             beat_i,
   input  crc_blockpipe_pkg::beat_ctl_t        ctl_i,
   output logic [GROUPS-1:0][CRC_W-1:0]        part_o,
   output crc_blockpipe_pkg::beat_ctl_t        ctl_o
);
   localparam int PER = BLOCKS / GROUPS;

   if (GROUPS < 1 || GROUPS > BLOCKS || (BLOCKS % GROUPS) != 0) begin : g_bad_groups
      $error("crc_prexor_stage: GROUPS must divide BLOCKS");
   end

   logic [CRC_W-1:0]             blk_x [BLOCKS];
   logic [GROUPS-1:0][CRC_W-1:0] grp_d;

   // Block k = 0 is leftmost (earliest); it is followed by (BLOCKS-1-k) blocks.
   for (genvar k = 0; k < BLOCKS; k++) begin : g_blk
      localparam int POS = BLOCKS - 1 - k;
      crc_zext_xform #(
         .CRC_W (CRC_W),
         .POLY  (POLY),
         .SHIFT (POS * CRC_W)
      ) u_xf (
         .vec_i (beat_i[POS*CRC_W +: CRC_W]),
         .vec_o (blk_x[k])
      );
   end

   always_comb begin
      for (int g = 0; g < GROUPS; g++) begin
         grp_d[g] = '0;
         for (int b = 0; b < PER; b++) grp_d[g] = grp_d[g] ^ blk_x[g*PER + b];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         part_o <= '0;
         ctl_o  <= '0;
      end else begin
         ctl_o <= ctl_i;
         if (ctl_i.valid) part_o <= grp_d;
      end
   end

endmodule

// File: rtl/crc_accum_stage.sv
module crc_accum_stage #(
   parameter int                CRC_W  = 32,
   parameter logic [CRC_W-1:0]  POLY   = 32'h04C1_1DB7,
   parameter int                BLOCKS = 4,
   parameter int                GROUPS = 2
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [GROUPS-1:0][CRC_W-1:0]  part_i,
   input  crc_blockpipe_pkg::beat_ctl_t  ctl_i,
   output logic [CRC_W-1:0]              crc_o,
   output logic                          crc_valid_o
);
   logic [CRC_W-1:0] rem_q;
   logic [CRC_W-1:0] rem_fb;
   logic [CRC_W-1:0] part_sum;
   logic [CRC_W-1:0] rem_next;

   // Remainder advanced past one whole beat of zeros.
   crc_zext_xform #(
      .CRC_W (CRC_W),
      .POLY  (POLY),
      .SHIFT (BLOCKS * CRC_W)
   ) u_fb (
      .vec_i (rem_q),
      .vec_o (rem_fb)
   );

   always_comb begin
      part_sum = '0;
      for (int g = 0; g < GROUPS; g++) part_sum = part_sum ^ part_i[g];
      rem_next = (ctl_i.first ? '0 : rem_fb) ^ part_sum;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rem_q       <= '0;
         crc_o       <= '0;
         crc_valid_o <= 1'b0;
      end else begin
         crc_valid_o <= ctl_i.valid & ctl_i.last;
         if (ctl_i.valid) rem_q <= rem_next;
         if (ctl_i.valid && ctl_i.last) crc_o <= rem_next;
      end
   end

   // R4
   bubble_keeps_rem_chk: assert property (@(posedge clk) disable iff (rst)
      !ctl_i.valid |=> $stable(rem_q));

endmodule

// File: rtl/crc32_blockpipe.sv
module crc32_blockpipe #(
   parameter int                CRC_W  = 32,
   parameter logic [CRC_W-1:0]  POLY   = 32'h04C1_1DB7,
   parameter int                BLOCKS = 4,
   parameter int                GROUPS = 2,
   localparam int               BEAT_W = BLOCKS * CRC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              beat_valid_i,
   input  logic              beat_last_i,
   input  logic [BEAT_W-1:0] beat_data_i,
   output logic [CRC_W-1:0]  crc_o,
   output logic              crc_valid_o
);
   import crc_blockpipe_pkg::*;

   if (BLOCKS < 1) begin : g_bad_blocks
      $error("crc32_blockpipe: BLOCKS must be at least 1");
   end

   logic                         fresh_q;
   beat_ctl_t                    ctl_in;
   beat_ctl_t                    ctl_s1;
   logic [GROUPS-1:0][CRC_W-1:0] part_s1;

   always_comb begin
      ctl_in.valid = beat_valid_i;
      ctl_in.first = start_i | fresh_q;
      ctl_in.last  = beat_last_i;
   end

   // Remembers that the next accepted beat opens a message.
   always_ff @(posedge clk) begin
      if (rst)               fresh_q <= 1'b1;
      else if (beat_valid_i) fresh_q <= beat_last_i;
      else if (start_i)      fresh_q <= 1'b1;
   end

   crc_prexor_stage #(
      .CRC_W  (CRC_W),
      .POLY   (POLY),
      .BLOCKS (BLOCKS),
      .GROUPS (GROUPS)
   ) u_pre (
      .clk    (clk),
      .rst    (rst),
      .beat_i (beat_data_i),
      .ctl_i  (ctl_in),
      .part_o (part_s1),
      .ctl_o  (ctl_s1)
   );

   crc_accum_stage #(
      .CRC_W  (CRC_W),
      .POLY   (POLY),
      .BLOCKS (BLOCKS),
      .GROUPS (GROUPS)
   ) u_acc (
      .clk         (clk),
      .rst         (rst),
      .part_i      (part_s1),
      .ctl_i       (ctl_s1),
      .crc_o       (crc_o),
      .crc_valid_o (crc_valid_o)
   );

   // R3
   last_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (beat_valid_i && beat_last_i) |-> ##2 crc_valid_o);

   // R3
   valid_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
      crc_valid_o |-> $past(beat_valid_i && beat_last_i, 2));

   // R8
   hold_output_chk: assert property (@(posedge clk) disable iff (rst)
      !crc_valid_o |-> $stable(crc_o));

endmodule

// File: tb/tb_crc32_blockpipe.sv
`timescale 1ns/1ps
module tb_crc32_blockpipe;

   localparam logic [31:0] GPOLY = 32'h04C1_1DB7;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start_i = 1'b0;
   logic         beat_valid_i = 1'b0;
   logic         beat_last_i = 1'b0;
   logic [127:0] beat_data_i = '0;
   logic [31:0]  crc_o;
   logic         crc_valid_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   logic [31:0] ref_r     = '0;
   bit          ref_fresh = 1'b1;
   logic [31:0] last_exp  = '0;
   logic [31:0] exp_crc [$];
   int          exp_due [$];
   string       exp_tag [$];

   localparam logic [127:0] VEC [8] = '{
      128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
      128'h0000_0000_0000_0000_0000_0000_0000_0000,
      128'h8000_0000_0000_0000_0000_0000_0000_0000,
      128'h0000_0000_0000_0000_0000_0001_0000_0000,
      128'hAAAA_AAAA_5555_5555_AAAA_AAAA_5555_5555,
      128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
      128'hDEAD_BEEF_0000_0000_0000_0000_CAFE_F00D,
      128'h0000_0000_FFFF_FFFF_0000_0000_FFFF_FFFF
   };

   crc32_blockpipe dut (
      .clk          (clk),
      .rst          (rst),
      .start_i      (start_i),
      .beat_valid_i (beat_valid_i),
      .beat_last_i  (beat_last_i),
      .beat_data_i  (beat_data_i),
      .crc_o        (crc_o),
      .crc_valid_o  (crc_valid_o)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] ref_step(input logic [31:0] r, input logic [127:0] d);
      logic msb;
      for (int i = 127; i >= 0; i--) begin
         msb = r[31];
         r   = {r[30:0], d[i]};
         if (msb) r = r ^ GPOLY;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // Result monitor: value and cycle of every valid pulse.
   always @(negedge clk) begin
      if (!rst && crc_valid_o) begin
         if (exp_crc.size() == 0) begin
            check(1'b0, "R3", "unexpected crc_valid_o", crc_o, 32'h0);
         end else begin
            logic [31:0] e;
            int          d;
            string       t;
            e = exp_crc.pop_front();
            d = exp_due.pop_front();
            t = exp_tag.pop_front();
            check(crc_o == e, t, "crc value", crc_o, e);
            check(cyc == d, "R3", "valid cycle", 32'(cyc), 32'(d));
         end
      end
   end

   task automatic send(input logic [127:0] d, input bit last, input bit start,
                       input string tag, input bit use_k, input logic [31:0] kval);
      @(negedge clk);
      start_i      = start;
      beat_valid_i = 1'b1;
      beat_last_i  = last;
      beat_data_i  = d;
      if (start || ref_fresh) ref_r = '0;
      ref_r     = ref_step(ref_r, d);
      ref_fresh = last;
      if (last) begin
         last_exp = use_k ? kval : ref_r;
         exp_crc.push_back(last_exp);
         exp_due.push_back(cyc + 2);
         exp_tag.push_back(tag);
      end
   endtask

   // Bubble cycles with garbage data and last (R4); optional start on the first.
   task automatic idle(input bit start, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start_i      = start && (i == 0);
         beat_valid_i = 1'b0;
         beat_last_i  = 1'($urandom);
         beat_data_i  = {$urandom, $urandom, $urandom, $urandom};
         if (start && i == 0) ref_fresh = 1'b1;
      end
   endtask

   function automatic logic [127:0] rnd_beat();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      #(8 * 60000);
      if (!done) begin
         n_fail++;
         $display("FAIL R2 watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // Reset state (R8)
      repeat (3) @(negedge clk);
      check(crc_valid_o == 1'b0, "R8", "valid in reset", 32'(crc_valid_o), 32'h0);
      rst = 1'b0;
      @(negedge clk);
      check(crc_o == 32'h0, "R8", "crc after reset", crc_o, 32'h0);
      check(crc_valid_o == 1'b0, "R8", "valid after reset", 32'(crc_valid_o), 32'h0);

      // Vector table: single-beat messages with start and last together (R1, R6)
      for (int i = 0; i < 8; i++) send(VEC[i], 1'b1, 1'b1, "R1", 1'b0, 32'h0);
      idle(1'b0, 4);

      // Rightmost-only and all-zero messages (R9)
      send(128'h0000_0000_0000_0000_0000_0000_DEAD_BEEF, 1'b1, 1'b0, "R9", 1'b1, 32'hDEAD_BEEF);
      send(128'h0, 1'b1, 1'b0, "R9", 1'b1, 32'h0);
      idle(1'b0, 4);

      // Output hold while valid low (R8)
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(crc_valid_o == 1'b0, "R8", "valid idle", 32'(crc_valid_o), 32'h0);
         check(crc_o == last_exp, "R8", "crc hold", crc_o, last_exp);
      end

      // Back-to-back multi-beat messages, no gaps (R2, R5)
      for (int m = 0; m < 20; m++) begin
         int len;
         len = 1 + int'($urandom % 6);
         for (int b = 0; b < len; b++) send(rnd_beat(), b == len - 1, 1'b0, "R5", 1'b0, 32'h0);
      end
      idle(1'b0, 4);

      // Messages with random bubbles carrying garbage (R4)
      for (int m = 0; m < 20; m++) begin
         int len;
         len = 1 + int'($urandom % 6);
         for (int b = 0; b < len; b++) begin
            send(rnd_beat(), b == len - 1, 1'b0, "R4", 1'b0, 32'h0);
            if ($urandom % 3 == 0) idle(1'b0, 1 + int'($urandom % 2));
         end
      end
      idle(1'b0, 4);

      // Start together with a valid beat mid-message (R6)
      send(rnd_beat(), 1'b0, 1'b0, "R6", 1'b0, 32'h0);
      send(rnd_beat(), 1'b0, 1'b0, "R6", 1'b0, 32'h0);
      send(rnd_beat(), 1'b0, 1'b1, "R6", 1'b0, 32'h0);
      send(rnd_beat(), 1'b1, 1'b0, "R6", 1'b0, 32'h0);
      // Start alone mid-message (R6)
      send(rnd_beat(), 1'b0, 1'b0, "R6", 1'b0, 32'h0);
      idle(1'b1, 2);
      send(rnd_beat(), 1'b0, 1'b0, "R6", 1'b0, 32'h0);
      send(rnd_beat(), 1'b1, 1'b0, "R6", 1'b0, 32'h0);
      idle(1'b0, 3);

      // Start in the cycle after a last beat, alone and with a beat (R7)
      send(rnd_beat(), 1'b0, 1'b0, "R7", 1'b0, 32'h0);
      send(rnd_beat(), 1'b1, 1'b0, "R7", 1'b0, 32'h0);
      idle(1'b1, 1);
      send(rnd_beat(), 1'b1, 1'b0, "R7", 1'b0, 32'h0);
      send(rnd_beat(), 1'b1, 1'b1, "R7", 1'b0, 32'h0);
      send(rnd_beat(), 1'b0, 1'b1, "R7", 1'b0, 32'h0);
      send(rnd_beat(), 1'b1, 1'b0, "R7", 1'b0, 32'h0);
      idle(1'b0, 6);

      check(exp_crc.size() == 0, "R3", "results outstanding", 32'(exp_crc.size()), 32'h0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule